// File: doc/BRIEF.md
# Configuration Port Key Unlock

This block sits on a legacy peripheral controller's I/O bus and guards its sixteen-byte configuration register file behind a key sequence. The host writes a key byte twice to an index port. After that the block is in configuration mode. In that mode, bytes written to the index port pick a register, and the data port writes or reads the picked register. Writing an exit byte to the index port locks the block again.

Selected register fields are decoded into static outputs for the serial, floppy and address logic next to the block:

- serial port enables and address selects
- serial clock divisor selects
- the alternate serial address select
- floppy enhanced-mode and floppy enable flags

Each data-port write is compared with the old register contents. For every field group whose bits changed, the block raises a one-cycle update strobe, so the neighbouring engines can re-evaluate their settings.

Top module: `sio_cfg_port`

## Requirements
- R1: While locked, each write of the key byte 0x55 to the index port (default 0x3F0) advances an unlock count. Configuration mode (`cfg_active`=1) begins when the count reaches two. The two key writes need not be back to back.
- R2: While locked, nothing advances the count: not index-port writes of other values, not writes to other addresses, not reads. Data-port writes made while locked leave the register file unchanged.
- R3: In configuration mode, a write of 0xAA to the index port clears the count and leaves configuration mode. Two fresh key writes are then needed to re-enter it.
- R4: In configuration mode, an index-port write of any other value selects register (value mod 16). A data-port write (default 0x3F1) stores its byte into the selected register.
- R5: A data-port read in configuration mode returns the selected register, with `bus_rdata` valid in the same cycle as `bus_rd`. Every other read returns 0x00, and so does every read while locked.
- R6: After reset the block is locked, the index is 0, register 0 holds 0x3A, and registers 1 to 15 hold 0x00.
- R7: Register 2 drives the serial port controls:
  - bit 2 drives `ser_en[0]`, and bits 1:0 drive `ser_addr_sel[1:0]`;
  - bit 6 drives `ser_en[1]`, and bits 5:4 drive `ser_addr_sel[3:2]`.
- R8: In register 4, bit 4 drives `ser_div12[0]` and bit 5 drives `ser_div12[1]`. A 1 selects the 24 MHz clock divided by 12, and a 0 selects it divided by 13.
- R9: Register 3 bit 1 drives `fdc_enh` and register 5 bit 0 drives `fdc_en`. Register 1 bits 6:5 drive `alt_sel`.
- R10: In the cycle after a data-port write, `upd` carries a strobe for each field group whose bits changed. The groups, by `upd` bit, are:
  - bit 0, serial 0: reg2 bits 2:0, reg4 bit 4, reg1 bits 6:5;
  - bit 1, serial 1: reg2 bits 6:4, reg4 bit 5, reg1 bits 6:5;
  - bit 2, alternate addresses: reg1 bits 6:5;
  - bit 3, floppy mode: reg3 bit 1;
  - bit 4, floppy enable: reg5 bit 0.

  In all other cycles `upd` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| cfg_active | output | 1 | Configuration mode is open |
| ser_en | output | 2 | Serial port enables |
| ser_addr_sel | output | 4 | Serial address selects, two bits per port |
| ser_div12 | output | 2 | Serial clock divisor select (1: /12, 0: /13) |
| alt_sel | output | 2 | Alternate serial address select |
| fdc_enh | output | 1 | Floppy enhanced mode |
| fdc_en | output | 1 | Floppy enable |
| upd | output | 5 | One-cycle field-change strobes |

## Verification
The bench keeps the default parameters: index port 0x3F0, data port 0x3F1, a key count of two and sixteen registers. With these values, the index values picked at random from the full byte range often exceed 15, which exercises the wrap onto the register file. Key and exit bytes are weighted heavily, so the block locks and unlocks many times in one run. The model cross-checks every bus cycle against the decoded outputs and strobes.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int GRP_N    = 5;
  localparam int GRP_SER0 = 0;
  localparam int GRP_SER1 = 1;
  localparam int GRP_ALT  = 2;
  localparam int GRP_FMOD = 3;
  localparam int GRP_FEN  = 4;

  // Field groups touched by a change mask on register idx.
  function automatic logic [GRP_N-1:0] change_groups(input logic [3:0] idx,
                                                     input logic [7:0] diff);
    logic [GRP_N-1:0] g;
    g = '0;
    case (idx)
      4'd1: if (|diff[6:5]) begin
        g[GRP_ALT]  = 1'b1;
        g[GRP_SER0] = 1'b1;
        g[GRP_SER1] = 1'b1;
      end
      4'd2: begin
        g[GRP_SER0] = |diff[2:0];
        g[GRP_SER1] = |diff[6:4];
      end
      4'd3: g[GRP_FMOD] = diff[1];
      4'd4: begin
        g[GRP_SER0] = diff[4];
        g[GRP_SER1] = diff[5];
      end
      4'd5: g[GRP_FEN] = diff[0];
      default: ;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/sio_key_lock.sv
module sio_key_lock #(
  parameter int          KEY_COUNT = 2,
  parameter logic [7:0]  KEY_VAL   = 8'h55,
  parameter logic [7:0]  EXIT_VAL  = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_active
);
  localparam int CW = $clog2(KEY_COUNT + 1);
  localparam logic [CW-1:0] CMAX = CW'(KEY_COUNT);

  logic [CW-1:0] cnt;
  logic key_hit, exit_hit;

  assign cfg_active = (cnt == CMAX);
  assign key_hit    = idx_wr && (wdata == KEY_VAL) && !cfg_active;
  assign exit_hit   = idx_wr && (wdata == EXIT_VAL) && cfg_active;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (exit_hit) cnt <= '0;
    else if (key_hit)  cnt <= cnt + 1'b1;
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CMAX);
  // R2
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_active && !(idx_wr && wdata == KEY_VAL)) |=> $stable(cnt));
  // R3
  exit_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_hit |=> (cnt == '0));
endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
  import sio_cfg_pkg::*;
#(
  parameter int         NREG     = 16,
  parameter logic [7:0] REG0_RST = 8'h3A,
  parameter logic [7:0] EXIT_VAL = 8'hAA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_active,
  input  logic             idx_wr,
  input  logic             data_wr,
  input  logic [7:0]       wdata,
  output logic [7:0]       regs_o [NREG],
  output logic [7:0]       sel_byte,
  output logic [GRP_N-1:0] upd_o
);
  localparam int IW = $clog2(NREG);

  logic [IW-1:0] cur_idx;
  logic          wr_evt, idx_evt;
  logic [7:0]    diff;

  assign wr_evt   = cfg_active && data_wr;
  assign idx_evt  = cfg_active && idx_wr && (wdata != EXIT_VAL);
  assign sel_byte = regs_o[cur_idx];
  assign diff     = sel_byte ^ wdata;

  always_ff @(posedge clk) begin
    if (!rst_n)       cur_idx <= '0;
    else if (idx_evt) cur_idx <= wdata[IW-1:0];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RV = (g == 0) ? REG0_RST : 8'h00;
    always_ff @(posedge clk) begin
      if (!rst_n)                                   regs_o[g] <= RV;
      else if (wr_evt && (cur_idx == IW'(g)))       regs_o[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      upd_o <= '0;
    else if (wr_evt) upd_o <= change_groups(4'(cur_idx), diff);
    else             upd_o <= '0;
  end

  // R10
  upd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_o) |-> $past(wr_evt));
  // R2
  locked_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active |=> $stable(sel_byte) || $past(idx_evt));
endmodule

// File: rtl/sio_field_decode.sv
module sio_field_decode (
  input  logic [7:0] r1,
  input  logic [7:0] r2,
  input  logic [7:0] r3,
  input  logic [7:0] r4,
  input  logic [7:0] r5,
  output logic [1:0] ser_en,
  output logic [3:0] ser_addr_sel,
  output logic [1:0] ser_div12,
  output logic [1:0] alt_sel,
  output logic       fdc_enh,
  output logic       fdc_en
);
  assign ser_en       = {r2[6], r2[2]};
  assign ser_addr_sel = {r2[5:4], r2[1:0]};
  assign ser_div12    = r4[5:4];
  assign alt_sel      = r1[6:5];
  assign fdc_enh      = r3[1];
  assign fdc_en       = r5[0];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] INDEX_ADDR = 16'h03F0,
  parameter logic [15:0] DATA_ADDR  = 16'h03F1,
  parameter int          KEY_COUNT  = 2,
  parameter int          NREG       = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        cfg_active,
  output logic [1:0]  ser_en,
  output logic [3:0]  ser_addr_sel,
  output logic [1:0]  ser_div12,
  output logic [1:0]  alt_sel,
  output logic        fdc_enh,
  output logic        fdc_en,
  output logic [4:0]  upd
);
  localparam logic [7:0] KEY_VAL  = 8'h55;
  localparam logic [7:0] EXIT_VAL = 8'hAA;

  logic       idx_wr, data_wr, data_rd;
  logic [7:0] regs [NREG];
  logic [7:0] sel_byte;

  assign idx_wr  = bus_wr && (bus_addr == INDEX_ADDR);
  assign data_wr = bus_wr && (bus_addr == DATA_ADDR);
  assign data_rd = bus_rd && (bus_addr == DATA_ADDR);

  sio_key_lock #(.KEY_COUNT(KEY_COUNT), .KEY_VAL(KEY_VAL), .EXIT_VAL(EXIT_VAL)) u_lock (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(bus_wdata),
    .cfg_active(cfg_active));

  sio_reg_bank #(.NREG(NREG), .REG0_RST(8'h3A), .EXIT_VAL(EXIT_VAL)) u_bank (
    .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active), .idx_wr(idx_wr),
    .data_wr(data_wr), .wdata(bus_wdata), .regs_o(regs), .sel_byte(sel_byte),
    .upd_o(upd));

  sio_field_decode u_dec (
    .r1(regs[1]), .r2(regs[2]), .r3(regs[3]), .r4(regs[4]), .r5(regs[5]),
    .ser_en(ser_en), .ser_addr_sel(ser_addr_sel), .ser_div12(ser_div12),
    .alt_sel(alt_sel), .fdc_enh(fdc_enh), .fdc_en(fdc_en));

  assign bus_rdata = (cfg_active && data_rd) ? sel_byte : 8'h00;

  // R9
  fdc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_wr && cfg_active) |-> $stable(fdc_enh) && $stable(fdc_en));
  // R5
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active |-> bus_rdata == 8'h00);
  // R8
  div_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_active) |-> $stable(ser_div12));
endmodule

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        cfg_active, fdc_enh, fdc_en;
  logic [1:0]  ser_en, ser_div12, alt_sel;
  logic [3:0]  ser_addr_sel;
  logic [4:0]  upd;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  logic [7:0] mreg [16];
  int         mcnt;
  logic [3:0] midx;
  logic [4:0] mupd;

  always #4 clk = ~clk;

  sio_cfg_port u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_active(cfg_active), .ser_en(ser_en), .ser_addr_sel(ser_addr_sel),
    .ser_div12(ser_div12), .alt_sel(alt_sel), .fdc_enh(fdc_enh), .fdc_en(fdc_en),
    .upd(upd));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [4:0] exp_groups(input logic [3:0] i, input logic [7:0] o, input logic [7:0] n);
    logic [4:0] s;
    logic alt;
    alt  = (i == 1) && (o[6:5] != n[6:5]);
    s[0] = alt || ((i == 2) && (o[2:0] != n[2:0])) || ((i == 4) && (o[4] != n[4]));
    s[1] = alt || ((i == 2) && (o[6:4] != n[6:4])) || ((i == 4) && (o[5] != n[5]));
    s[2] = alt;
    s[3] = (i == 3) && (o[1] != n[1]);
    s[4] = (i == 5) && (o[0] != n[0]);
    return s;
  endfunction

  task automatic check_outs();
    check("R1 R3 mode", cfg_active, mcnt == 2);
    check("R7 serial", {ser_en, ser_addr_sel}, {mreg[2][6], mreg[2][2], mreg[2][5:4], mreg[2][1:0]});
    check("R8 divisor", ser_div12, {mreg[4][5], mreg[4][4]});
    check("R9 floppy/alt", {fdc_enh, fdc_en, alt_sel}, {mreg[3][1], mreg[5][0], mreg[1][6:5]});
    check("R10 strobes", upd, mupd);
  endtask

  // One bus cycle; starts and ends at a negedge.
  task automatic bus_op(input logic [15:0] a, input bit w, input bit r, input logic [7:0] d);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    #1;
    if (r) check("R5 read", bus_rdata,
                 (mcnt == 2 && a == 16'h3F1) ? mreg[midx] : 8'h00);
    @(posedge clk);
    mupd = '0;
    if (w && a == 16'h3F0) begin
      if (mcnt < 2) begin if (d == 8'h55) mcnt++; end
      else if (d == 8'hAA) mcnt = 0;
      else midx = d[3:0];
    end else if (w && a == 16'h3F1 && mcnt == 2) begin
      mupd = exp_groups(midx, mreg[midx], d);
      mreg[midx] = d;
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    check_outs();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'd20201116));
    for (int i = 0; i < 16; i++) mreg[i] = 8'h00;
    mreg[0] = 8'h3A; mcnt = 0; midx = 0; mupd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check_outs(); // R6 decoded outputs from reset
    // R2: locked data write and non-key traffic are ignored
    bus_op(16'h3F1, 1, 0, 8'hFF);
    bus_op(16'h3F0, 0, 1, 8'h00);
    bus_op(16'h2F0, 1, 0, 8'h55);
    bus_op(16'h3F0, 1, 0, 8'h55);
    bus_op(16'h3F0, 1, 0, 8'h12);   // R1 key writes need not be adjacent
    check("R2 still locked", cfg_active, 1'b0);
    bus_op(16'h3F0, 1, 0, 8'h55);
    check("R1 unlocked", cfg_active, 1'b1);
    bus_op(16'h3F1, 0, 1, 8'h00);   // R6 reg0 = 0x3A via index 0
    bus_op(16'h3F0, 1, 0, 8'h21);   // R4 wraps to 1
    bus_op(16'h3F1, 1, 0, 8'h60);   // R10 alt change strobes three groups
    check("R10 alt strobes", upd, 5'b00111);
    bus_op(16'h3F1, 0, 1, 8'h00);
    check("R10 strobe clears", upd, 5'b0);
    bus_op(16'h3F0, 1, 0, 8'hAA);   // R3 relock
    check("R3 relocked", cfg_active, 1'b0);
    bus_op(16'h3F0, 1, 0, 8'h55);
    check("R3 one key not enough", cfg_active, 1'b0);
    for (int n = 0; n < 1500; n++) begin
      int unsigned r;
      r = $urandom % 12;
      case (r)
        0, 1, 2: bus_op(16'h3F0, 1, 0, 8'h55);
        3:       bus_op(16'h3F0, 1, 0, 8'hAA);
        4:       bus_op(16'h3F0, 1, 0, 8'($urandom % 6));
        5:       bus_op(16'h3F0, 1, 0, 8'($urandom));
        6, 7, 8: bus_op(16'h3F1, 1, 0, 8'($urandom));
        9, 10:   bus_op(16'h3F1, 0, 1, 8'h00);
        default: bus_op(16'h3F2, ($urandom % 2) == 1, 1, 8'($urandom));
      endcase
    end
    done = 1;
    finish_run();
  end
endmodule